// File: doc/BRIEF.md
# Active-Priority Register Access Decoder

This block sits beside the system-register access path of a processor core. For each request it receives the five encoding fields of a system-register instruction, the access direction, the current privilege level, a 3-bit nested-virtualization control field, two register-interface enable bits (one for level 2 and one for level 3), the implemented count of preemption bits, and flags for the features that are present. It decides what happens to an access to one of the four active-priority registers. The access may go ahead on register m, be redirected to a memory address, trap to a given privilege level with a syndrome class, or be rejected as an undefined instruction.

Encodings that do not select one of the four registers are reported as no-match and get none of the four results. The decision is registered, so the result appears one clock after the request. The block does not hold the registers, issue the memory access or run exception entry. A surrounding pipeline acts on its response.

Top module: `apr_access_dec`

## Requirements
- R1: A request matches when the encoding fields are space=2'b11, opc1=3'b100, major=4'b1100, minor=4'b1001 and opc2[2]=0. The register index m is opc2[1:0]. A non-matching request gives rsp_nomatch=1 and rsp_kind=4'b0000.
- R2: rsp_valid is 1 exactly in the cycle after a cycle with req_valid=1. When rsp_valid is 0, rsp_kind is 4'b0000.
- R3: A matching request gives undefined when any of these is clear: has_intc, has_wide, or both has_lvl2 and has_lvl3.
- R4: Index m=1 with prio_bits<6 is undefined. Index m=2 or m=3 with prio_bits<7 is undefined. This check is applied before any privilege-level rule.
- R5: A matching, otherwise permitted request from level 0 is undefined.
- R6: From level 1, nest_ctl matching 1x1 gives a redirect with rsp_addr = 0x4A0 + 8*m.
- R7: From level 1, nest_ctl matching xx1 but not 1x1 gives a trap to level 2 with class 0x18. Every other nest_ctl value is undefined.
- R8: From level 2, en_lvl2=0 gives a trap to level 2 with class 0x18. en_lvl2=1 gives an access to register m.
- R9: From level 3, en_lvl3=0 gives a trap to level 3 with class 0x18. en_lvl3=1 gives an access to register m.
- R10: After a synchronous active-low reset, rsp_valid=0 and rsp_kind=4'b0000.
- R11: rsp_kind is one-hot with bit0=access, bit1=redirect, bit2=trap and bit3=undefined. rsp_lvl and rsp_class are zero unless the result is a trap. rsp_addr is zero unless the result is a redirect. rsp_index and rsp_write echo m and req_write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = register write, 0 = register read |
| enc_space | input | 2 | Encoding space field |
| enc_opc1 | input | 3 | First opcode field |
| enc_major | input | 4 | Major register field |
| enc_minor | input | 4 | Minor register field |
| enc_opc2 | input | 3 | Second opcode field; bits [1:0] carry the index |
| cur_lvl | input | 2 | Current privilege level 0..3 |
| nest_ctl | input | 3 | Nested-virtualization control field |
| en_lvl2 | input | 1 | Register interface enable at level 2 |
| en_lvl3 | input | 1 | Register interface enable at level 3 |
| prio_bits | input | 3 | Implemented preemption bits (5..7) |
| has_intc | input | 1 | Interrupt-controller register interface present |
| has_lvl2 | input | 1 | Level 2 implemented |
| has_lvl3 | input | 1 | Level 3 implemented |
| has_wide | input | 1 | 64-bit execution state present |
| rsp_valid | output | 1 | Response valid |
| rsp_nomatch | output | 1 | Encoding did not select an active-priority register |
| rsp_kind | output | 4 | One-hot result code |
| rsp_lvl | output | 2 | Trap target level |
| rsp_class | output | 6 | Trap syndrome class |
| rsp_addr | output | 16 | Redirect address |
| rsp_index | output | 2 | Register index m |
| rsp_write | output | 1 | Echo of the access direction |

## Verification
On every cycle the assertions check these properties:
- Response timing follows the request.
- The result code is one-hot.
- A no-match response carries no result.
- A level-0 match is undefined.
- Every trap carries class 0x18.
- A redirect address follows the index.

The choice between redirect, trap, undefined and access depends on the exact priority among features, preemption bits, privilege level, the nest_ctl pattern and the enable bits. Only the bench scenarios can show this. They sweep all of these combinations and compare each response against an independent model.

// File: rtl/apr_dec_pkg.sv
// Package: shared result encoding and widths for the active-priority
// access decoder. Assumes the result code is consumed as a one-hot vector.
package apr_dec_pkg;
    localparam int KIND_W = 4;
    localparam int CLS_W  = 6;
    localparam int LVL_W  = 2;

    typedef enum logic [KIND_W-1:0] {
        RES_NONE     = 4'b0000,
        RES_ACCESS   = 4'b0001,
        RES_REDIRECT = 4'b0010,
        RES_TRAP     = 4'b0100,
        RES_UNDEF    = 4'b1000
    } res_kind_e;

    typedef struct packed {
        res_kind_e        kind;
        logic [LVL_W-1:0] lvl;
        logic [CLS_W-1:0] cls;
    } decision_t;
endpackage

// File: rtl/apr_enc_match.sv
// Encoding matcher: compares the instruction fields with the fixed pattern
// that selects the active-priority registers and extracts the index.
// Assumes the low IDX_W bits of opc2 carry the index and the rest must be 0.
module apr_enc_match #(
    parameter int          IDX_W   = 2,
    parameter logic [1:0]  M_SPACE = 2'b11,
    parameter logic [2:0]  M_OPC1  = 3'b100,
    parameter logic [3:0]  M_MAJOR = 4'b1100,
    parameter logic [3:0]  M_MINOR = 4'b1001
) (
    input  logic [1:0]       space,
    input  logic [2:0]       opc1,
    input  logic [3:0]       major,
    input  logic [3:0]       minor,
    input  logic [2:0]       opc2,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    localparam int HI_W = 3 - IDX_W;

    // Compare every fixed field and require the upper opc2 bits to be zero.
    always_comb begin
        hit = (space == M_SPACE) && (opc1 == M_OPC1) && (major == M_MAJOR)
              && (minor == M_MINOR) && (opc2[2 -: HI_W] == '0);
        idx = opc2[IDX_W-1:0];
    end
endmodule

// File: rtl/apr_lvl_resolve.sv
// Privilege resolver: ranks the feature, preemption-bit, privilege-level,
// nesting-pattern and enable rules into one decision. Assumes the
// encoding has already matched; the caller gates the result otherwise.
module apr_lvl_resolve
    import apr_dec_pkg::*;
#(
    parameter int                IDX_W      = 2,
    parameter int                MIN_BITS_1 = 6,
    parameter int                MIN_BITS_2 = 7,
    parameter logic [CLS_W-1:0]  TRAP_CLS   = 6'h18
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       cur_lvl,
    input  logic [2:0]       nest_ctl,
    input  logic             en_lvl2,
    input  logic             en_lvl3,
    input  logic [2:0]       prio_bits,
    input  logic             has_intc,
    input  logic             has_lvl2,
    input  logic             has_lvl3,
    input  logic             has_wide,
    output decision_t        dec
);
    logic feat_ok;
    logic idx_bad;

    // Feature gate: the interface, a higher level and the wide state must exist.
    always_comb feat_ok = has_intc && (has_lvl2 || has_lvl3) && has_wide;

    // Index gate: higher registers need more implemented preemption bits.
    always_comb begin
        idx_bad = 1'b0;
        if (idx == IDX_W'(1) && int'(prio_bits) < MIN_BITS_1) idx_bad = 1'b1;
        if (idx[IDX_W-1]    && int'(prio_bits) < MIN_BITS_2) idx_bad = 1'b1;
    end

    // Priority chain: gates first, then the rule of the current level.
    always_comb begin
        dec = '{kind: RES_UNDEF, lvl: '0, cls: '0};
        if (feat_ok && !idx_bad) begin
            unique case (cur_lvl)
                2'd0: dec.kind = RES_UNDEF;
                2'd1: begin
                    if (nest_ctl[2] && nest_ctl[0]) begin
                        dec.kind = RES_REDIRECT;
                    end else if (nest_ctl[0]) begin
                        dec = '{kind: RES_TRAP, lvl: 2'd2, cls: TRAP_CLS};
                    end else begin
                        dec.kind = RES_UNDEF;
                    end
                end
                2'd2: begin
                    if (en_lvl2) dec.kind = RES_ACCESS;
                    else         dec = '{kind: RES_TRAP, lvl: 2'd2, cls: TRAP_CLS};
                end
                default: begin
                    if (en_lvl3) dec.kind = RES_ACCESS;
                    else         dec = '{kind: RES_TRAP, lvl: 2'd3, cls: TRAP_CLS};
                end
            endcase
        end
    end
endmodule

// File: rtl/apr_redir_addr.sv
// Redirect address generator: builds a table of BASE + STRIDE*k, one entry
// per register, and selects the entry for the index. Assumes the sum
// fits in ADDR_W bits.
module apr_redir_addr #(
    parameter int IDX_W  = 2,
    parameter int ADDR_W = 16,
    parameter int BASE   = 'h4A0,
    parameter int STRIDE = 8
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int NREG = 1 << IDX_W;

    logic [ADDR_W-1:0] tbl [NREG];

    // One constant address per register slot.
    for (genvar g = 0; g < NREG; g++) begin : g_slot
        assign tbl[g] = ADDR_W'(BASE + STRIDE * g);
    end

    // Select the slot addressed by the index.
    always_comb addr = tbl[idx];
endmodule

// File: rtl/apr_access_dec.sv
// Top: registers the decision for an active-priority register access one
// cycle after a valid request. Assumes one request per cycle at most and
// a synchronous active-low reset.
module apr_access_dec
    import apr_dec_pkg::*;
#(
    parameter int IDX_W      = 2,
    parameter int ADDR_W     = 16,
    parameter int RED_BASE   = 'h4A0,
    parameter int RED_STRIDE = 8,
    parameter int MIN_BITS_1 = 6,
    parameter int MIN_BITS_2 = 7,
    parameter int TRAP_CLS   = 'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        enc_space,
    input  logic [2:0]        enc_opc1,
    input  logic [3:0]        enc_major,
    input  logic [3:0]        enc_minor,
    input  logic [2:0]        enc_opc2,
    input  logic [1:0]        cur_lvl,
    input  logic [2:0]        nest_ctl,
    input  logic              en_lvl2,
    input  logic              en_lvl3,
    input  logic [2:0]        prio_bits,
    input  logic              has_intc,
    input  logic              has_lvl2,
    input  logic              has_lvl3,
    input  logic              has_wide,
    output logic              rsp_valid,
    output logic              rsp_nomatch,
    output logic [KIND_W-1:0] rsp_kind,
    output logic [LVL_W-1:0]  rsp_lvl,
    output logic [CLS_W-1:0]  rsp_class,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [IDX_W-1:0]  rsp_index,
    output logic              rsp_write
);
    localparam logic [CLS_W-1:0] TCLS = CLS_W'(TRAP_CLS);

    logic              hit;
    logic [IDX_W-1:0]  idx;
    decision_t         dec;
    logic [ADDR_W-1:0] red_addr;

    apr_enc_match #(.IDX_W(IDX_W)) u_match (
        .space(enc_space), .opc1(enc_opc1), .major(enc_major),
        .minor(enc_minor), .opc2(enc_opc2), .hit(hit), .idx(idx)
    );

    apr_lvl_resolve #(
        .IDX_W(IDX_W), .MIN_BITS_1(MIN_BITS_1), .MIN_BITS_2(MIN_BITS_2),
        .TRAP_CLS(TCLS)
    ) u_resolve (
        .idx(idx), .cur_lvl(cur_lvl), .nest_ctl(nest_ctl),
        .en_lvl2(en_lvl2), .en_lvl3(en_lvl3), .prio_bits(prio_bits),
        .has_intc(has_intc), .has_lvl2(has_lvl2), .has_lvl3(has_lvl3),
        .has_wide(has_wide), .dec(dec)
    );

    apr_redir_addr #(
        .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BASE(RED_BASE), .STRIDE(RED_STRIDE)
    ) u_addr (
        .idx(idx), .addr(red_addr)
    );

    // Response register: capture the gated decision, or clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_nomatch <= 1'b0;
            rsp_kind    <= RES_NONE;
            rsp_lvl     <= '0;
            rsp_class   <= '0;
            rsp_addr    <= '0;
            rsp_index   <= '0;
            rsp_write   <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_nomatch <= req_valid && !hit;
            rsp_kind    <= (req_valid && hit) ? dec.kind : RES_NONE;
            rsp_lvl     <= (req_valid && hit) ? dec.lvl  : '0;
            rsp_class   <= (req_valid && hit) ? dec.cls  : '0;
            rsp_addr    <= (req_valid && hit && dec.kind == RES_REDIRECT) ? red_addr : '0;
            rsp_index   <= req_valid ? idx : '0;
            rsp_write   <= req_valid && req_write;
        end
    end

    // Response appears exactly one cycle after a request.
    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_rsp_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && rsp_kind == '0);
    // A non-matching encoding yields no result.
    p_nomatch_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit) |=> rsp_nomatch && rsp_kind == '0);
    // A matching response carries exactly one result.
    p_kind_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_nomatch) |-> $countones(rsp_kind) == 1);
    // Level 0 never reaches a register or a redirect.
    p_lvl0_undef_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && cur_lvl == 2'd0) |=> rsp_kind == RES_UNDEF);
    // Every trap carries the fixed class and targets level 2 or 3.
    p_trap_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_kind == RES_TRAP) |-> rsp_class == TCLS && rsp_lvl[1]);
    // Redirect address tracks the registered index.
    p_redir_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_kind == RES_REDIRECT) |->
            rsp_addr == ADDR_W'(RED_BASE + RED_STRIDE * int'(rsp_index)));
endmodule

// File: tb/tb_apr_access_dec.sv
// Scoreboard bench: the driver pushes model results into a queue and a
// monitor pops them as responses appear.
module tb_apr_access_dec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] enc_space = 2'b11;
    logic [2:0] enc_opc1 = 3'b100;
    logic [3:0] enc_major = 4'b1100, enc_minor = 4'b1001;
    logic [2:0] enc_opc2 = 3'b000;
    logic [1:0] cur_lvl = 2'd2;
    logic [2:0] nest_ctl = 3'b000;
    logic       en_lvl2 = 1'b1, en_lvl3 = 1'b1;
    logic [2:0] prio_bits = 3'd7;
    logic       has_intc = 1'b1, has_lvl2 = 1'b1, has_lvl3 = 1'b1, has_wide = 1'b1;
    logic       rsp_valid, rsp_nomatch, rsp_write;
    logic [3:0] rsp_kind;
    logic [1:0] rsp_lvl, rsp_index;
    logic [5:0] rsp_class;
    logic [15:0] rsp_addr;

    typedef struct packed {
        logic        nm;
        logic [3:0]  kind;
        logic [1:0]  lvl;
        logic [5:0]  cls;
        logic [15:0] addr;
        logic [1:0]  idx;
        logic        wr;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0, errors = 0;

    always #5 clk = ~clk;

    apr_access_dec dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .enc_space(enc_space), .enc_opc1(enc_opc1), .enc_major(enc_major),
        .enc_minor(enc_minor), .enc_opc2(enc_opc2), .cur_lvl(cur_lvl),
        .nest_ctl(nest_ctl), .en_lvl2(en_lvl2), .en_lvl3(en_lvl3),
        .prio_bits(prio_bits), .has_intc(has_intc), .has_lvl2(has_lvl2),
        .has_lvl3(has_lvl3), .has_wide(has_wide), .rsp_valid(rsp_valid),
        .rsp_nomatch(rsp_nomatch), .rsp_kind(rsp_kind), .rsp_lvl(rsp_lvl),
        .rsp_class(rsp_class), .rsp_addr(rsp_addr), .rsp_index(rsp_index),
        .rsp_write(rsp_write)
    );

    // Reference model written from the requirements.
    function automatic exp_t model();
        exp_t e = '0;
        logic [1:0] m = enc_opc2[1:0];
        e.idx = m;
        e.wr  = req_write;
        if (!(enc_space == 2'b11 && enc_opc1 == 3'b100 && enc_major == 4'b1100 &&
              enc_minor == 4'b1001 && !enc_opc2[2])) begin
            e.nm = 1'b1;                                   // R1
            return e;
        end
        e.kind = 4'b1000;
        if (!has_intc || !has_wide || (!has_lvl2 && !has_lvl3)) return e;   // R3
        if (m == 2'd1 && prio_bits < 3'd6) return e;                        // R4
        if (m >= 2'd2 && prio_bits < 3'd7) return e;                        // R4
        case (cur_lvl)
            2'd0: e.kind = 4'b1000;                                         // R5
            2'd1: if (nest_ctl[2] && nest_ctl[0]) begin                     // R6
                      e.kind = 4'b0010; e.addr = 16'h04A0 + 16'(8 * m);
                  end else if (nest_ctl[0]) begin                           // R7
                      e.kind = 4'b0100; e.lvl = 2'd2; e.cls = 6'h18;
                  end
            2'd2: if (en_lvl2) e.kind = 4'b0001;                            // R8
                  else begin e.kind = 4'b0100; e.lvl = 2'd2; e.cls = 6'h18; end
            default: if (en_lvl3) e.kind = 4'b0001;                         // R9
                  else begin e.kind = 4'b0100; e.lvl = 2'd3; e.cls = 6'h18; end
        endcase
        return e;
    endfunction

    // Driver: issue one request at a falling edge and push its expectation.
    task automatic send(input logic [2:0] opc2, input string tag);
        enc_opc2  = opc2;
        req_valid = 1'b1;
        exp_q.push_back(model());
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check(input logic ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    // Monitor: compare each response with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            exp_t  a, e;
            string t;
            a = '{rsp_nomatch, rsp_kind, rsp_lvl, rsp_class, rsp_addr, rsp_index, rsp_write};
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", $sformatf("unexpected response actual=%h expected=none", a));
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(a == e, t, $sformatf("actual=%h expected=%h", a, e));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rsp_valid == 1'b0 && rsp_kind == 4'b0000, "R10",
              $sformatf("actual valid=%b kind=%b expected valid=0 kind=0000", rsp_valid, rsp_kind));
        rst_n = 1'b1;
        @(negedge clk);

        // R1: non-matching encodings, one field off at a time
        enc_opc1 = 3'b000; send(3'b000, "R1"); enc_opc1 = 3'b100;
        enc_minor = 4'b1000; send(3'b001, "R1"); enc_minor = 4'b1001;
        enc_space = 2'b10; send(3'b000, "R1"); enc_space = 2'b11;
        enc_major = 4'b1101; send(3'b000, "R1"); enc_major = 4'b1100;
        send(3'b100, "R1");
        send(3'b111, "R1");

        // R2: idle cycles produce no response
        @(negedge clk); @(negedge clk);
        check(rsp_valid == 1'b0, "R2", $sformatf("actual valid=%b expected 0", rsp_valid));

        // R3: each missing feature
        has_intc = 1'b0; send(3'b000, "R3"); has_intc = 1'b1;
        has_wide = 1'b0; send(3'b000, "R3"); has_wide = 1'b1;
        has_lvl2 = 1'b0; has_lvl3 = 1'b0; send(3'b000, "R3");
        has_lvl2 = 1'b1; send(3'b000, "R3_one_level_ok");
        has_lvl3 = 1'b1;

        // R4: index gate wins over a level-1 redirect pattern
        cur_lvl = 2'd1; nest_ctl = 3'b101; prio_bits = 3'd5;
        send(3'b001, "R4"); send(3'b010, "R4"); send(3'b000, "R4_idx0_ok");
        prio_bits = 3'd6; send(3'b001, "R4"); send(3'b011, "R4");
        prio_bits = 3'd7; send(3'b011, "R4");

        // R5: level 0
        cur_lvl = 2'd0; send(3'b000, "R5");

        // R6: redirect addresses for every index
        cur_lvl = 2'd1; nest_ctl = 3'b111;
        for (int m = 0; m < 4; m++) send({1'b0, 2'(m)}, "R6");

        // R7: trap and undefined patterns
        nest_ctl = 3'b001; send(3'b000, "R7");
        nest_ctl = 3'b011; send(3'b010, "R7");
        nest_ctl = 3'b100; send(3'b000, "R7");
        nest_ctl = 3'b110; send(3'b000, "R7");

        // R8 / R9: enables at levels 2 and 3, with writes
        req_write = 1'b1;
        cur_lvl = 2'd2; en_lvl2 = 1'b0; send(3'b001, "R8");
        en_lvl2 = 1'b1; send(3'b001, "R8");
        cur_lvl = 2'd3; en_lvl3 = 1'b0; send(3'b010, "R9");
        en_lvl3 = 1'b1; send(3'b011, "R9");
        req_write = 1'b0;

        // R11: exhaustive sweep of levels, patterns, enables, indices, bits
        for (int l = 0; l < 4; l++)
            for (int n = 0; n < 8; n++)
                for (int en = 0; en < 4; en++)
                    for (int p = 5; p < 8; p++)
                        for (int m = 0; m < 4; m++) begin
                            cur_lvl = 2'(l); nest_ctl = 3'(n);
                            en_lvl2 = en[0]; en_lvl3 = en[1];
                            prio_bits = 3'(p); req_write = m[0];
                            send({1'b0, 2'(m)}, "R11");
                        end

        @(negedge clk); @(negedge clk);
        check(exp_q.size() == 0, "R2",
              $sformatf("actual pending=%0d expected 0", exp_q.size()));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule